// File: doc/BRIEF.md
# Separate-I/O Burst-of-Two DDR SRAM Port

This block models the device side of a double-data-rate SRAM that has a write-only data input bus and a read-only data output bus. Commands arrive on the rising edges of the command clock. Each accepted command moves exactly two data beats to or from a pair of words in an internal array. The read/write protocol does not force reads and writes to alternate. The controller may issue an unbroken run of reads or an unbroken run of writes, and each run keeps its own data bus busy on every half-cycle.

One fast clock `clk` stands for both clock edges. Its even edges after reset are the command-clock rising edges (the K phase). Its odd edges are the rising edges of the complementary clock (the K# phase). The input `out_clk_en` says whether the optional output clock is in use. When it is low, read beats launch on K-domain edges. When it is high, each beat launches one half-cycle later, on the output-clock edge. The command address selects a word pair. Beat 0 always maps to the even word of that pair and beat 1 to the odd word.

Top module: `sio_ddr_sram`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `rvalid` is 0 and `rdata` is all zeros.
- R2: A K-phase edge with `load_n` high starts nothing. No read beats follow, and the value on `wdata` is not stored. Command pins are also ignored on K#-phase edges.
- R3: A K-phase edge with `load_n` low and `rw_sel` high starts a read of pair `addr`. It produces exactly two beats: first word `{addr,0}`, then word `{addr,1}`.
- R4: A K-phase edge with `load_n` low and `rw_sel` low starts a write of pair `addr`. `wdata` is stored into word `{addr,0}` at the next K-phase edge and into word `{addr,1}` at the K#-phase edge right after it.
- R5: With `out_clk_en` low, read beat 0 is on the outputs after the second `clk` edge following the command edge, and beat 1 is on the outputs after the third.
- R6: With `out_clk_en` high, each read beat appears one `clk` edge later than in R5.
- R7: Reads issued on consecutive K-phase edges give an unbroken stream of beats, with `rvalid` high on every half-cycle.
- R8: Writes issued on consecutive K-phase edges are all stored. A read issued on the K-phase edge right after a write to the same pair returns the new data. A write issued right after a read of the same pair does not change that read's data.
- R9: Whenever no read beat is being driven, `rvalid` is 0 and `rdata` is all zeros.
- R10: Strictly alternating read and write commands are accepted and each completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; alternate edges are the K and K# phases |
| rst | input | 1 | Synchronous active-high reset; the first edge after it is a K phase |
| load_n | input | 1 | Active-low command strobe; high means deselect |
| rw_sel | input | 1 | 1 selects read, 0 selects write |
| addr | input | AW | Word-pair address |
| wdata | input | DW | Write data beats |
| out_clk_en | input | 1 | High when the output clock times the read beats |
| rdata | output | DW | Read data beats, zero when idle |
| rvalid | output | 1 | High while a read beat is on `rdata` |

## Verification
The bench builds the block with `AW=3` and `DW=16`. This gives eight word pairs, so one back-to-back run of writes followed by one run of reads covers the whole array and every even/odd word. Same-pair write-then-read and read-then-write orderings are then cheap to stage. Both settings of `out_clk_en` are run, so that each read beat can be matched to its exact half-cycle in both launch modes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    PH_K  = 1'b0,
    PH_KN = 1'b1
  } phase_e;
endpackage

// File: rtl/sio_cmd_seq.sv
module sio_cmd_seq
  import sio_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          rw_sel,
  input  logic [AW-1:0] addr,
  output logic          re,
  output logic [AW:0]   raddr,
  output logic          we,
  output logic [AW:0]   waddr
);
  phase_e ph;
  logic   k_edge, go;
  logic   rd_s1, rd_s2, wr_s1, wr_s2, wr_s3;
  logic [AW-1:0] rd_a1, rd_a2, wr_a1, wr_a2, wr_a3;

  assign k_edge = (ph == PH_K);
  assign go     = k_edge && !load_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_K;
      rd_s1 <= 1'b0;
      rd_s2 <= 1'b0;
      wr_s1 <= 1'b0;
      wr_s2 <= 1'b0;
      wr_s3 <= 1'b0;
    end else begin
      ph    <= k_edge ? PH_KN : PH_K;
      rd_s1 <= go && rw_sel;
      rd_s2 <= rd_s1;
      wr_s1 <= go && !rw_sel;
      wr_s2 <= wr_s1;
      wr_s3 <= wr_s2;
    end
  end

  // address pipeline, no reset needed
  always_ff @(posedge clk) begin
    if (go) begin
      rd_a1 <= addr;
      wr_a1 <= addr;
    end
    rd_a2 <= rd_a1;
    wr_a2 <= wr_a1;
    wr_a3 <= wr_a2;
  end

  // even word on the half-cycle after the command, odd word next
  assign re    = rd_s1 | rd_s2;
  assign raddr = rd_s1 ? {rd_a1, 1'b0} : {rd_a2, 1'b1};
  assign we    = wr_s2 | wr_s3;
  assign waddr = wr_s2 ? {wr_a2, 1'b0} : {wr_a3, 1'b1};

  AST_DESEL_NO_START: assert property (@(posedge clk) disable iff (rst)
    (k_edge && load_n) |=> (!rd_s1 && !wr_s1)); // R2
  AST_READ_START: assert property (@(posedge clk) disable iff (rst)
    (k_edge && !load_n && rw_sel) |=> (rd_s1 && !wr_s1)); // R3
  AST_EVEN_WORD_ON_K: assert property (@(posedge clk) disable iff (rst)
    wr_s2 |-> k_edge); // R4
endmodule

// File: rtl/sio_pair_ram.sv
module sio_pair_ram #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW:0]   raddr,
  output logic [DW-1:0] rq,
  output logic          rtag
);
  localparam int DEPTH = 2 ** (AW + 1);

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, synchronous read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rq <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rtag <= 1'b0;
    else     rtag <= re;
  end

  AST_NO_SAME_WORD_RW: assert property (@(posedge clk) disable iff (rst)
    !(we && re && (waddr == raddr))); // R8
endmodule

// File: rtl/sio_rd_launch.sv
module sio_rd_launch #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          out_clk_en,
  input  logic          beat_v,
  input  logic [DW-1:0] beat_d,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          dly_v;
  logic [DW-1:0] dly_d;
  logic [DW-1:0] fast_d;

  assign fast_d = beat_v ? beat_d : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_v  <= 1'b0;
      dly_d  <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      dly_v <= beat_v;
      dly_d <= fast_d;
      if (out_clk_en) begin
        rvalid <= dly_v;
        rdata  <= dly_d;
      end else begin
        rvalid <= beat_v;
        rdata  <= fast_d;
      end
    end
  end

  AST_LAUNCH_ON_K: assert property (@(posedge clk) disable iff (rst)
    (!out_clk_en && beat_v) |=> rvalid); // R5
  AST_LAUNCH_ON_C: assert property (@(posedge clk) disable iff (rst)
    (out_clk_en && dly_v) |=> rvalid); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> (rdata == '0)); // R9
endmodule

// File: rtl/sio_ddr_sram.sv
module sio_ddr_sram #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          rw_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          out_clk_en,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          re, we, rtag;
  logic [AW:0]   raddr, waddr;
  logic [DW-1:0] rq;

  sio_cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .load_n(load_n), .rw_sel(rw_sel), .addr(addr),
    .re(re), .raddr(raddr), .we(we), .waddr(waddr)
  );

  sio_pair_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rq(rq), .rtag(rtag)
  );

  sio_rd_launch #(.DW(DW)) u_launch (
    .clk(clk), .rst(rst), .out_clk_en(out_clk_en),
    .beat_v(rtag), .beat_d(rq), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: tb/sim_sio_ddr_sram.sv
module sim_sio_ddr_sram;
  localparam int AW = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_n = 1'b1;
  logic          rw_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          out_clk_en = 1'b0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;
  bit done = 1'b0;

  int          exp_cyc[$];
  logic [DW-1:0] exp_dat[$];
  string       exp_tag[$];

  logic [DW-1:0] shadow [2**(AW+1)];
  bit            pw = 1'b0;
  logic [DW-1:0] pd0, pd1;

  always #4 clk = ~clk;  // 125 MHz

  sio_ddr_sram #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .rw_sel(rw_sel), .addr(addr),
    .wdata(wdata), .out_clk_en(out_clk_en), .rdata(rdata), .rvalid(rvalid)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // monitor: pops expected beats at their exact half-cycle
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        nchk++; nbad++;
        $display("FAIL %s: beat due at %0d missing, actual rvalid=%0b expected data %h",
                 exp_tag[0], exp_cyc[0], rvalid, exp_dat[0]);
        void'(exp_cyc.pop_front()); void'(exp_dat.pop_front()); void'(exp_tag.pop_front());
      end
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        nchk++;
        if (!rvalid || rdata !== exp_dat[0]) begin
          nbad++;
          $display("FAIL %s: cycle %0d actual rvalid=%0b rdata=%h expected rvalid=1 rdata=%h",
                   exp_tag[0], cyc, rvalid, rdata, exp_dat[0]);
        end
        void'(exp_cyc.pop_front()); void'(exp_dat.pop_front()); void'(exp_tag.pop_front());
      end else begin
        nchk++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
          nbad++;
          $display("FAIL R9: cycle %0d actual rvalid=%0b rdata=%h expected rvalid=0 rdata=0",
                   cyc, rvalid, rdata);
        end
      end
    end
  end

  // one command slot = one K edge plus one K# edge; entered at a negedge
  task automatic slot(input logic ld, input logic rw, input logic [AW-1:0] a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1, input string tag);
    int ce;
    int off;
    ce  = cyc + 1;
    off = out_clk_en ? 1 : 0;
    load_n = ld; rw_sel = rw; addr = a;
    wdata  = pw ? pd0 : DW'($urandom);
    if (!ld && rw) begin
      exp_cyc.push_back(ce + 2 + off); exp_dat.push_back(shadow[{a, 1'b0}]); exp_tag.push_back(tag);
      exp_cyc.push_back(ce + 3 + off); exp_dat.push_back(shadow[{a, 1'b1}]); exp_tag.push_back(tag);
    end
    @(negedge clk);
    // K# half: command pins carry noise that must be ignored (R2)
    load_n = 1'($urandom); rw_sel = 1'($urandom); addr = AW'($urandom);
    wdata  = pw ? pd1 : DW'($urandom);
    pw  = !ld && !rw;
    pd0 = d0; pd1 = d1;
    if (pw) begin
      shadow[{a, 1'b0}] = d0;
      shadow[{a, 1'b1}] = d1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 1'($urandom), AW'($urandom), '0, '0, "R2");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    nchk++;
    if (rvalid !== 1'b0 || rdata !== '0) begin
      nbad++;
      $display("FAIL R1: actual rvalid=%0b rdata=%h expected 0/0", rvalid, rdata);
    end
    rst = 1'b0;

    // R4/R8: back-to-back writes over the whole array
    for (int i = 0; i < 8; i++)
      slot(1'b0, 1'b0, AW'(i), DW'(16'h1000 + 2*i), DW'(16'h2001 + 2*i), "R4");
    // R3/R5/R7: back-to-back reads
    for (int i = 0; i < 8; i++) slot(1'b0, 1'b1, AW'(i), '0, '0, "R7");
    idle(2);
    // R2: deselect with write intent and data, then read back unchanged
    slot(1'b1, 1'b0, 3'd2, 16'hBAD0, 16'hBAD1, "R2");
    slot(1'b1, 1'b1, 3'd2, '0, '0, "R2");
    idle(1);
    slot(1'b0, 1'b1, 3'd2, '0, '0, "R2");
    idle(2);
    // R8: write then read same pair; read then write same pair
    slot(1'b0, 1'b0, 3'd5, 16'hA5A5, 16'h5A5A, "R8");
    slot(1'b0, 1'b1, 3'd5, '0, '0, "R8");
    slot(1'b0, 1'b1, 3'd6, '0, '0, "R8");
    slot(1'b0, 1'b0, 3'd6, 16'hC0DE, 16'hFACE, "R8");
    slot(1'b0, 1'b1, 3'd6, '0, '0, "R8");
    idle(2);
    // R10: strict alternation
    for (int i = 0; i < 6; i++) begin
      slot(1'b0, 1'b0, AW'(i), DW'(16'h3300 + i), DW'(16'h4400 + i), "R10");
      slot(1'b0, 1'b1, AW'(i), '0, '0, "R10");
    end
    idle(3);
    // R6: output clock in use
    out_clk_en = 1'b1;
    idle(2);
    for (int i = 0; i < 8; i++) slot(1'b0, 1'b1, AW'(7 - i), '0, '0, "R6");
    idle(1);
    slot(1'b0, 1'b0, 3'd1, 16'h7E57, 16'h0DD1, "R6");
    slot(1'b0, 1'b1, 3'd1, '0, '0, "R6");
    slot(1'b0, 1'b0, 3'd3, 16'h1111, 16'h2222, "R6");
    slot(1'b0, 1'b1, 3'd3, '0, '0, "R6");
    idle(4);
    nchk++;
    if (exp_cyc.size() != 0) begin
      nbad++;
      $display("FAIL R3: actual %0d beats outstanding expected 0", exp_cyc.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule